// File: doc/BRIEF.md
# Byte-Lane Logic Unit

This block is a small execution unit for a 32-bit integer pipeline. It takes two source operands, a 16-bit upper immediate, a 4-bit lane mask and a 2-bit operation code, and it produces one 32-bit result. It supports three operations. The first ANDs the first operand with the immediate placed in the upper half, and forces the lower half of that mask to ones. The second ORs the immediate into the upper half of the first operand. The third builds a word byte by byte, taking each byte lane from one of the two operands as the mask selects.

The unit has no internal state apart from an optional output stage. With `REGISTER_OUT = 1` (the default), the result, a valid strobe and an illegal-operation flag appear one clock after the inputs are sampled. The output stage has an active-low synchronous reset. The destination register may be the same as the first source, because every operand is read before any result is written back. The unit takes no part in decode, register-file access or flag generation.

Top module: `bytelane_logic_unit`

## Requirements
- R1: With op code 2'b00, result equals src_a AND {imm_hi, 16'hFFFF}.
- R2: With op code 2'b01, result equals src_a OR {imm_hi, 16'h0000}.
- R3: With op code 2'b10, byte lane i of the result (lane 0 = bits 7:0, lane 3 = bits 31:24) is taken from src_b when lane_mask[i] is 1 and from src_a when it is 0, with no sign or zero fill.
- R4: For op codes 2'b00 and 2'b01, bits 15:0 of the result always equal bits 15:0 of src_a, whatever the value of imm_hi.
- R5: Op code 2'b11 is reserved. It yields a zero result with illegal_op = 1. The other three codes yield illegal_op = 0.
- R6: result, result_valid and illegal_op reflect the inputs sampled at one rising edge and stay stable until the next edge. result_valid equals the in_valid that was sampled at that edge.
- R7: While rst_n is low at a rising edge, result, result_valid and illegal_op are all cleared to 0 after that edge.
- R8: For the merge, a mask of 4'b0000 returns src_a exactly and a mask of 4'b1111 returns src_b exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The operands and the op code are valid this cycle |
| op_code | input | 2 | 00 AND-upper-ones, 01 OR-upper, 10 lane merge, 11 reserved |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand (used by the merge only) |
| imm_hi | input | 16 | Immediate that is placed in the upper halfword |
| lane_mask | input | 4 | Per-lane select for the merge; 1 takes src_b |
| result | output | 32 | Registered result |
| result_valid | output | 1 | Registered copy of in_valid |
| illegal_op | output | 1 | Registered flag for the reserved op code |

## Verification
Every result is due exactly one rising edge after its inputs are driven. The bench changes its inputs on the falling edge and reads the outputs on the next falling edge, so exactly one register sits between stimulus and sample. One scenario also reads the outputs shortly after the inputs change and before the edge, to show that the old value is still held there, which pins the latency at one cycle and not zero. The reset check samples on the falling edge after a rising edge at which reset was low.

// File: rtl/blu_pkg.sv
package blu_pkg;
    typedef enum logic [1:0] {
        OP_AND_HI = 2'b00,
        OP_OR_HI  = 2'b01,
        OP_MERGE  = 2'b10,
        OP_RSVD   = 2'b11
    } blu_op_e;
endpackage

// File: rtl/blu_upper_imm.sv
module blu_upper_imm #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [IMM_W-1:0]  imm,
    input  logic              or_mode,
    output logic [DATA_W-1:0] y
);
    localparam int LOW_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] and_mask;
    logic [DATA_W-1:0] or_bits;

    always_comb begin
        and_mask = {imm, {LOW_W{1'b1}}};
        or_bits  = {imm, {LOW_W{1'b0}}};
        y        = or_mode ? (a | or_bits) : (a & and_mask);
    end
endmodule

// File: rtl/blu_lane_merge.sv
module blu_lane_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] a,
    input  logic [LANES*LANE_W-1:0] b,
    input  logic [LANES-1:0]        sel_b,
    output logic [LANES*LANE_W-1:0] y
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign y[g*LANE_W +: LANE_W] = sel_b[g] ? b[g*LANE_W +: LANE_W]
                                                : a[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/blu_out_stage.sv
module blu_out_stage #(
    parameter int DATA_W    = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_res,
    input  logic              d_vld,
    input  logic              d_ill,
    output logic [DATA_W-1:0] q_res,
    output logic              q_vld,
    output logic              q_ill
);
    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_res <= '0;
                q_vld <= 1'b0;
                q_ill <= 1'b0;
            end else begin
                q_res <= d_res;
                q_vld <= d_vld;
                q_ill <= d_ill;
            end
        end
    end else begin : g_comb
        assign q_res = d_res;
        assign q_vld = d_vld;
        assign q_ill = d_ill;
    end
endmodule

// File: rtl/bytelane_logic_unit.sv
module bytelane_logic_unit
    import blu_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int IMM_W        = 16,
    parameter int LANE_W       = 8,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [1:0]                 op_code,
    input  logic [DATA_W-1:0]          src_a,
    input  logic [DATA_W-1:0]          src_b,
    input  logic [IMM_W-1:0]           imm_hi,
    input  logic [DATA_W/LANE_W-1:0]   lane_mask,
    output logic [DATA_W-1:0]          result,
    output logic                       result_valid,
    output logic                       illegal_op
);
    localparam int LANES = DATA_W / LANE_W;

    blu_op_e           op;
    logic [DATA_W-1:0] upper_y;
    logic [DATA_W-1:0] merge_y;
    logic [DATA_W-1:0] next_res;
    logic              next_ill;

    assign op = blu_op_e'(op_code);

    blu_upper_imm #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_upper (
        .a       (src_a),
        .imm     (imm_hi),
        .or_mode (op == OP_OR_HI),
        .y       (upper_y)
    );

    blu_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .a     (src_a),
        .b     (src_b),
        .sel_b (lane_mask),
        .y     (merge_y)
    );

    always_comb begin
        next_res = '0;
        next_ill = 1'b0;
        unique case (op)
            OP_AND_HI, OP_OR_HI: next_res = upper_y;
            OP_MERGE:            next_res = merge_y;
            OP_RSVD:             next_ill = 1'b1;
            default:             next_ill = 1'b1;
        endcase
    end

    blu_out_stage #(.DATA_W(DATA_W), .REGISTERED(REGISTER_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_res (next_res),
        .d_vld (in_valid),
        .d_ill (next_ill),
        .q_res (result),
        .q_vld (result_valid),
        .q_ill (illegal_op)
    );
endmodule

// File: rtl/bytelane_logic_unit_chk.sv
module bytelane_logic_unit_chk #(
    parameter int DATA_W       = 32,
    parameter int IMM_W        = 16,
    parameter int LANE_W       = 8,
    parameter bit REGISTER_OUT = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [1:0]               op_code,
    input logic [DATA_W-1:0]        src_a,
    input logic [DATA_W-1:0]        src_b,
    input logic [IMM_W-1:0]         imm_hi,
    input logic [DATA_W/LANE_W-1:0] lane_mask,
    input logic [DATA_W-1:0]        result,
    input logic                     result_valid,
    input logic                     illegal_op
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int LOW_W = DATA_W - IMM_W;

    function automatic logic [DATA_W-1:0] widen(input logic [LANES-1:0] m);
        logic [DATA_W-1:0] w;
        for (int i = 0; i < DATA_W; i++) w[i] = m[i / LANE_W];
        return w;
    endfunction

    if (REGISTER_OUT) begin : g_props
        a_r1_and_upper: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code == 2'b00) |=> result == ($past(src_a) & {$past(imm_hi), {LOW_W{1'b1}}}));

        a_r2_or_upper: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code == 2'b01) |=> result == ($past(src_a) | {$past(imm_hi), {LOW_W{1'b0}}}));

        a_r3_lane_merge: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code == 2'b10) |=> result == (($past(src_b) & widen($past(lane_mask)))
                                            | ($past(src_a) & ~widen($past(lane_mask)))));

        a_r4_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code[1] == 1'b0) |=> result[LOW_W-1:0] == $past(src_a[LOW_W-1:0]));

        a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (illegal_op == ($past(op_code) == 2'b11))
                     && (!illegal_op || result == '0));

        a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> result_valid == $past(in_valid));

        a_r7_reset_clears: assert property (@(posedge clk)
            !rst_n |=> (result == '0 && !result_valid && !illegal_op));
    end
endmodule

bind bytelane_logic_unit bytelane_logic_unit_chk #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .LANE_W(LANE_W), .REGISTER_OUT(REGISTER_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .imm_hi(imm_hi), .lane_mask(lane_mask),
    .result(result), .result_valid(result_valid), .illegal_op(illegal_op)
);

// File: tb/tb_bytelane_logic_unit.sv
`timescale 1ns/1ps
module tb_bytelane_logic_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm_hi = '0;
    logic [3:0]  lane_mask = '0;
    logic [31:0] result;
    logic        result_valid;
    logic        illegal_op;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    bytelane_logic_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .imm_hi(imm_hi), .lane_mask(lane_mask),
        .result(result), .result_valid(result_valid), .illegal_op(illegal_op)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] im,
                                          input logic [3:0] m);
        logic [31:0] r;
        case (op)
            2'b00: r = a & {im, 16'hFFFF};
            2'b01: r = a | {im, 16'h0000};
            2'b10: for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? b[i*8 +: 8] : a[i*8 +: 8];
            default: r = 32'h0;
        endcase
        return r;
    endfunction

    task automatic apply(input logic v, input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] im, input logic [3:0] m);
        in_valid = v; op_code = op; src_a = a; src_b = b; imm_hi = im; lane_mask = m;
        @(negedge clk);
    endtask

    task automatic t_reset();
        apply(1'b1, 2'b11, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 4'hF);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 result", result, 32'h0);
        chk("R7 valid", {31'h0, result_valid}, 32'h0);
        chk("R7 illegal", {31'h0, illegal_op}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_and_upper();
        apply(1'b1, 2'b00, 32'h1234_5678, 32'h0, 16'h0F0F, 4'h0);
        chk("R1 and-upper", result, 32'h0204_5678);
        chk("R5 legal op flag", {31'h0, illegal_op}, 32'h0);
        apply(1'b1, 2'b00, 32'hDEAD_BEEF, 32'h0, 16'h0000, 4'h0);
        chk("R4 and-upper zero imm low kept", result, 32'h0000_BEEF);
    endtask

    task automatic t_or_upper();
        apply(1'b1, 2'b01, 32'h1200_00FF, 32'h0, 16'hA0A0, 4'h0);
        chk("R2 or-upper", result, 32'hB2A0_00FF);
        apply(1'b1, 2'b01, 32'h0000_0000, 32'h0, 16'hFFFF, 4'h0);
        chk("R4 or-upper full imm low kept", result, 32'hFFFF_0000);
    endtask

    task automatic t_merge();
        apply(1'b1, 2'b10, 32'hAABB_CCDD, 32'h1122_3344, 16'h0, 4'b0101);
        chk("R3 merge 0101", result, 32'hAA22_CC44);
        apply(1'b1, 2'b10, 32'hAABB_CCDD, 32'h1122_3344, 16'h0, 4'b1000);
        chk("R3 merge lane3", result, 32'h11BB_CCDD);
        apply(1'b1, 2'b10, 32'hAABB_CCDD, 32'h1122_3344, 16'h0, 4'b0000);
        chk("R8 merge none", result, 32'hAABB_CCDD);
        apply(1'b1, 2'b10, 32'hAABB_CCDD, 32'h1122_3344, 16'h0, 4'b1111);
        chk("R8 merge all", result, 32'h1122_3344);
    endtask

    task automatic t_reserved();
        apply(1'b1, 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 4'hF);
        chk("R5 reserved result", result, 32'h0);
        chk("R5 reserved flag", {31'h0, illegal_op}, 32'h1);
    endtask

    task automatic t_timing();
        apply(1'b1, 2'b01, 32'h0000_0001, 32'h0, 16'h0000, 4'h0);
        in_valid = 1'b0; op_code = 2'b01; src_a = 32'h0000_0002; imm_hi = 16'h8000;
        #2;
        chk("R6 old value held before edge", result, 32'h0000_0001);
        chk("R6 old valid held", {31'h0, result_valid}, 32'h1);
        @(negedge clk);
        chk("R6 new value after edge", result, 32'h8000_0002);
        chk("R6 valid follows in_valid", {31'h0, result_valid}, 32'h0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 60; i++) begin
            logic [1:0]  op = 2'($urandom);
            logic [31:0] a  = $urandom;
            logic [31:0] b  = $urandom;
            logic [15:0] im = 16'($urandom);
            logic [3:0]  m  = 4'($urandom);
            apply(1'b1, op, a, b, im, m);
            chk("R1 R2 R3 R5 random", result, model(op, a, b, im, m));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_and_upper();
        t_or_upper();
        t_merge();
        t_reserved();
        t_timing();
        t_random();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule